// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller handles one instruction cache miss at a time. When a miss request arrives with its physical address, it chooses a victim way from that set's least-recently-used state and fetches the whole 32-byte line as four 8-byte beats. It issues one memory read per beat. The first read is for the beat that holds the missed address, and the following reads step upward through the line, wrapping at its end. Each returned beat is written straight into the chosen way's data array.

The line becomes visible to lookups only after the whole line is in place. One cycle after the final beat arrives, the controller writes the tag and marks the entry valid. In the same cycle it moves the filled way to most-recent in the replacement state. Hits reported by the lookup path also refresh that state.

A demand miss stalls the requester until the critical beat arrives. That beat is then handed over on a forward strobe. A prefetch miss never stalls the requester and never forwards any data.

Top module: `icache_refill_ctrl`

## Requirements
- R1: The victim way is the least recently used way of the addressed set. After reset, every set ranks its ways by recency with way 3 newest and way 0 oldest, so the first victim in any set is way 0.
- R2: The controller issues exactly four memory reads per fill. Each read address is 8-byte aligned and shares bits [31:5] with the miss address.
- R3: Beat indices, taken from address bits [4:3], start at the missed beat and increase by one modulo 4.
- R4: Each memory response is written to the data array in its arrival cycle. The write carries the response data, the victim way, the set (address bits [10:5]) and the beat index.
- R5: For a demand miss, req_stall is high from the cycle after acceptance through the cycle the first beat arrives. In that cycle fwd_valid pulses with the first beat's data, and req_stall is low from the next cycle on.
- R6: For a prefetch miss, req_stall and fwd_valid both stay low for the whole fill.
- R7: tag_wr_en pulses exactly once per fill, in the cycle after the last beat's response. It carries the tag (address bits [31:11]), the set and the victim way, and it never appears earlier in the fill.
- R8: A committed fill makes its way the most recently used way of its set.
- R9: A hit_valid pulse makes hit_way the most recently used way of hit_set. If a hit and a commit land on the same set in the same cycle, the commit is applied last.
- R10: req_ready is high only when no fill is in progress. It drops the cycle after acceptance and returns the cycle after the commit. Requests made while it is low are ignored and do not change the memory addresses being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request |
| req_addr | input | 32 | Physical address of the miss |
| req_prefetch | input | 1 | Request is a prefetch (non-stalling) |
| req_ready | output | 1 | Controller idle, request will be accepted |
| req_stall | output | 1 | Demand requester must wait |
| fwd_valid | output | 1 | Critical beat forwarded to requester |
| fwd_data | output | 64 | Forwarded critical beat |
| hit_valid | input | 1 | Lookup hit, refresh replacement state |
| hit_set | input | 6 | Set of the hit |
| hit_way | input | 2 | Way of the hit |
| mem_req_valid | output | 1 | Beat read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Aligned beat address |
| mem_rsp_valid | input | 1 | Beat data returned |
| mem_rsp_data | input | 64 | Beat data |
| dwr_en | output | 1 | Data array write |
| dwr_way | output | 2 | Data array way |
| dwr_set | output | 6 | Data array set |
| dwr_beat | output | 2 | Beat within the line |
| dwr_data | output | 64 | Data to write |
| tag_wr_en | output | 1 | Tag write with valid set |
| tag_wr_way | output | 2 | Way being committed |
| tag_wr_set | output | 6 | Set being committed |
| tag_wr_tag | output | 21 | Tag being committed |

## Verification
Faults in the replacement state appear at the ports only when the next fill of the same set writes into the wrong way. They are visible in the first data array write of that fill. This is why the tests chain several fills and hits on one set and compare dwr_way for each fill. A broken beat counter shows up within one beat as an out-of-order read address, or as a tag commit that comes too early or too late. A broken stall flag shows up at the first response of a demand or prefetch fill.

// File: rtl/refill_pkg.sv
package refill_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_WAIT   = 2'd2,
      ST_COMMIT = 2'd3
   } fill_state_e;
endpackage

// File: rtl/lru_pairwise_store.sv
module lru_pairwise_store #(
   parameter int WAYS = 4,
   parameter int SETS = 64,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int PAIRS = WAYS * (WAYS - 1) / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAY_W-1:0] victim,
   input  logic             hit_en,
   input  logic [SET_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way
);
   // bit pidx(i,j), i<j: 1 means way i is newer than way j
   logic [PAIRS-1:0] order_q [SETS];
   logic [PAIRS-1:0] order_d [SETS];
   logic [PAIRS-1:0] cur;
   logic [WAYS-1:0]  victim_oh;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two and at least 2");
   end
   if (SETS < 1 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end

   function automatic int pidx(input int i, input int j);
      return i * WAYS - (i * (i + 1)) / 2 + (j - i - 1);
   endfunction

   function automatic logic [PAIRS-1:0] touch(input logic [PAIRS-1:0] v,
                                              input logic [WAY_W-1:0] w);
      logic [PAIRS-1:0] r;
      r = v;
      for (int i = 0; i < WAYS; i++) begin
         for (int j = i + 1; j < WAYS; j++) begin
            if (WAY_W'(i) == w)      r[pidx(i, j)] = 1'b1;
            else if (WAY_W'(j) == w) r[pidx(i, j)] = 1'b0;
         end
      end
      return r;
   endfunction

   assign cur = order_q[rd_set];

   always_comb begin
      victim_oh = '1;
      victim    = '0;
      for (int w = 0; w < WAYS; w++) begin
         for (int j = 0; j < WAYS; j++) begin
            if (j < w && !cur[pidx(j, w)]) victim_oh[w] = 1'b0;
            if (j > w &&  cur[pidx(w, j)]) victim_oh[w] = 1'b0;
         end
      end
      for (int w = 0; w < WAYS; w++) begin
         if (victim_oh[w]) victim = WAY_W'(w);
      end
   end

   // hit applied first, fill commit last
   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         order_d[s] = order_q[s];
         if (hit_en && hit_set == SET_W'(s))   order_d[s] = touch(order_d[s], hit_way);
         if (fill_en && fill_set == SET_W'(s)) order_d[s] = touch(order_d[s], fill_way);
      end
   end

   always_ff @(posedge clk) begin
      for (int s = 0; s < SETS; s++) begin
         if (!rst_n) order_q[s] <= '0;
         else        order_q[s] <= order_d[s];
      end
   end

   // R1: the stored recency order always names exactly one oldest way
   p_single_victim_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(victim_oh) == 1);
endmodule

// File: rtl/wrap_beat_seq.sv
module wrap_beat_seq #(
   parameter int BEATS = 4,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int CNT_W = BEAT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] start_beat,
   input  logic              advance,
   output logic [BEAT_W-1:0] beat,
   output logic              first,
   output logic              last
);
   logic [BEAT_W-1:0] crit_q;
   logic [CNT_W-1:0]  cnt_q;

   if (BEATS < 2 || (1 << BEAT_W) != BEATS) begin : g_bad_beats
      $error("BEATS must be a power of two and at least 2");
   end

   // truncating add gives the wraparound
   assign beat  = crit_q + cnt_q[BEAT_W-1:0];
   assign first = (cnt_q == '0);
   assign last  = (cnt_q == CNT_W'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crit_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         crit_q <= start_beat;
         cnt_q  <= '0;
      end else if (advance) begin
         cnt_q  <= last ? '0 : cnt_q + 1'b1;
      end
   end

   // R3: after a non-final beat the index steps by one modulo the line
   p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !last && !load) |=> beat == BEAT_W'($past(beat) + 1'b1));
endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
   import refill_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int BEAT_BYTES = 8,
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int OFF_W  = $clog2(BEAT_BYTES),
   localparam int LINE_W = $clog2(LINE_BYTES),
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int TAG_W  = ADDR_W - LINE_W - SET_W,
   localparam int DATA_W = BEAT_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_prefetch,
   output logic              req_ready,
   output logic              req_stall,
   output logic              fwd_valid,
   output logic [DATA_W-1:0] fwd_data,
   input  logic              hit_valid,
   input  logic [SET_W-1:0]  hit_set,
   input  logic [WAY_W-1:0]  hit_way,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              dwr_en,
   output logic [WAY_W-1:0]  dwr_way,
   output logic [SET_W-1:0]  dwr_set,
   output logic [BEAT_W-1:0] dwr_beat,
   output logic [DATA_W-1:0] dwr_data,
   output logic              tag_wr_en,
   output logic [WAY_W-1:0]  tag_wr_way,
   output logic [SET_W-1:0]  tag_wr_set,
   output logic [TAG_W-1:0]  tag_wr_tag
);
   if ((1 << OFF_W) != BEAT_BYTES) begin : g_bad_beat_bytes
      $error("BEAT_BYTES must be a power of two");
   end
   if ((1 << LINE_W) != LINE_BYTES || LINE_BYTES < 2 * BEAT_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two beats");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   fill_state_e       state_q;
   logic [SET_W-1:0]  set_q;
   logic [TAG_W-1:0]  tag_q;
   logic [WAY_W-1:0]  way_q;
   logic              pf_q;
   logic              stall_q;
   logic              accept;
   logic              rsp_take;
   logic [BEAT_W-1:0] beat;
   logic              beat_first;
   logic              beat_last;
   logic [WAY_W-1:0]  victim;
   logic [SET_W-1:0]  req_set;

   assign req_set  = req_addr[LINE_W +: SET_W];
   assign accept   = req_valid && (state_q == ST_IDLE);
   assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid;

   lru_pairwise_store #(.WAYS(WAYS), .SETS(SETS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (req_set),
      .victim   (victim),
      .hit_en   (hit_valid),
      .hit_set  (hit_set),
      .hit_way  (hit_way),
      .fill_en  (tag_wr_en),
      .fill_set (set_q),
      .fill_way (way_q)
   );

   wrap_beat_seq #(.BEATS(BEATS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .start_beat (req_addr[OFF_W +: BEAT_W]),
      .advance    (rsp_take),
      .beat       (beat),
      .first      (beat_first),
      .last       (beat_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         set_q   <= '0;
         tag_q   <= '0;
         way_q   <= '0;
         pf_q    <= 1'b0;
         stall_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_ISSUE;
               set_q   <= req_set;
               tag_q   <= req_addr[ADDR_W-1 -: TAG_W];
               way_q   <= victim;
               pf_q    <= req_prefetch;
               stall_q <= !req_prefetch;
            end
            ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               state_q <= beat_last ? ST_COMMIT : ST_ISSUE;
               if (beat_first) stall_q <= 1'b0;
            end
            ST_COMMIT: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign req_stall     = stall_q;
   assign mem_req_valid = (state_q == ST_ISSUE);
   assign mem_req_addr  = {tag_q, set_q, beat, OFF_W'(0)};
   assign dwr_en        = rsp_take;
   assign dwr_way       = way_q;
   assign dwr_set       = set_q;
   assign dwr_beat      = beat;
   assign dwr_data      = mem_rsp_data;
   assign fwd_valid     = rsp_take && beat_first && !pf_q;
   assign fwd_data      = mem_rsp_data;
   assign tag_wr_en     = (state_q == ST_COMMIT);
   assign tag_wr_way    = way_q;
   assign tag_wr_set    = set_q;
   assign tag_wr_tag    = tag_q;

   // R7: a commit always follows a data array write
   p_commit_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en |-> $past(dwr_en));
   // R5: the critical beat is forwarded while the requester is still held
   p_fwd_while_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> req_stall);
   // R6: an accepted prefetch never stalls the requester
   p_prefetch_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_prefetch) |=> !req_stall);
   // R10: only one fill at a time
   p_one_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   // R2: no read request while a commit is being made
   p_no_read_in_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en |-> !mem_req_valid);
endmodule

// File: tb/icache_refill_ctrl_test.sv
`timescale 1ns/1ps
module icache_refill_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_prefetch = 1'b0;
   logic        req_ready, req_stall, fwd_valid;
   logic [63:0] fwd_data;
   logic        hit_valid = 1'b0;
   logic [5:0]  hit_set = '0;
   logic [1:0]  hit_way = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        dwr_en;
   logic [1:0]  dwr_way;
   logic [5:0]  dwr_set;
   logic [1:0]  dwr_beat;
   logic [63:0] dwr_data;
   logic        tag_wr_en;
   logic [1:0]  tag_wr_way;
   logic [5:0]  tag_wr_set;
   logic [20:0] tag_wr_tag;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   icache_refill_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_prefetch(req_prefetch),
      .req_ready(req_ready), .req_stall(req_stall),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data),
      .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_set(dwr_set),
      .dwr_beat(dwr_beat), .dwr_data(dwr_data),
      .tag_wr_en(tag_wr_en), .tag_wr_way(tag_wr_way),
      .tag_wr_set(tag_wr_set), .tag_wr_tag(tag_wr_tag)
   );

   task automatic chk(input bit ok, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic do_hit(input logic [5:0] s, input logic [1:0] w);
      @(negedge clk);
      hit_valid = 1'b1; hit_set = s; hit_way = w;
      @(negedge clk);
      hit_valid = 1'b0;
   endtask

   // one full refill with an in-line memory model
   task automatic run_fill(input logic [31:0] addr, input bit pf,
                           input logic [1:0] exp_way, input bit poke_busy,
                           input bit hit_at_commit, input logic [1:0] hit_w);
      logic [1:0]  crit;
      logic [5:0]  set;
      crit = addr[4:3];
      set  = addr[10:5];
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_addr = addr; req_prefetch = pf;
      @(negedge clk);
      req_valid = poke_busy;
      req_addr  = addr ^ 32'h0004_0048;
      for (int k = 0; k < 4; k++) begin
         logic [1:0]  b;
         logic [31:0] baddr;
         int n;
         b = crit + 2'(k);
         baddr = {addr[31:5], b, 3'b000};
         n = 0;
         while (!mem_req_valid && n < 20) begin
            @(negedge clk);
            n++;
         end
         chk(mem_req_valid && mem_req_addr == baddr, "R3 R2 beat read address",
             64'(mem_req_addr), 64'(baddr));
         chk(tag_wr_en == 1'b0, "R7 no commit before last beat", 64'(tag_wr_en), 64'd0);
         if (k == 0) chk(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
         if (k == 0) chk(req_stall == !pf, "R5 R6 stall during critical wait",
                         64'(req_stall), 64'(!pf));
         if (k == 1) chk(req_stall == 1'b0, "R5 stall released after forward",
                         64'(req_stall), 64'd0);
         @(negedge clk);
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = {baddr, ~baddr};
         #1;
         chk(dwr_en && dwr_beat == b && dwr_set == set && dwr_data == {baddr, ~baddr},
             "R4 data array write", {56'(dwr_set), dwr_beat, 5'(dwr_en)}, {56'(set), b, 5'd1});
         chk(dwr_way == exp_way, "R1 victim way", 64'(dwr_way), 64'(exp_way));
         chk(fwd_valid == (k == 0 && !pf), "R5 R6 forward strobe",
             64'(fwd_valid), 64'(k == 0 && !pf));
         if (k == 0 && !pf) chk(fwd_data == {baddr, ~baddr}, "R5 forwarded data",
                                fwd_data, {baddr, ~baddr});
         @(negedge clk);
         mem_rsp_valid = 1'b0;
      end
      req_valid = 1'b0;
      chk(tag_wr_en && tag_wr_tag == addr[31:11] && tag_wr_set == set && tag_wr_way == exp_way,
          "R7 tag commit", {tag_wr_tag, tag_wr_set, tag_wr_way, 1'(tag_wr_en)},
          {addr[31:11], set, exp_way, 1'b1});
      if (hit_at_commit) begin
         hit_valid = 1'b1; hit_set = set; hit_way = hit_w;
      end
      @(negedge clk);
      hit_valid = 1'b0;
      chk(tag_wr_en == 1'b0 && req_ready == 1'b1, "R10 R7 idle after single commit",
          {62'(tag_wr_en), 1'(req_ready)}, 64'd1);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
      chk(!req_stall && !mem_req_valid && !dwr_en && !tag_wr_en && !fwd_valid,
          "R5 R7 reset outputs quiet",
          {59'd0, req_stall, mem_req_valid, dwr_en, tag_wr_en, fwd_valid}, 64'd0);
   endtask

   task automatic t_demand_wrap;
      // set 5, start at beat 2, with a request poked while busy (R10)
      run_fill({21'h01234, 6'd5, 2'd2, 3'd0}, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0);
   endtask

   task automatic t_lru_chain;
      // R8: previous commit made way 0 newest, so way 1 is next
      run_fill({21'h00777, 6'd5, 2'd0, 3'd0}, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0);
      // R9: hit on way 2 leaves way 3 oldest; start at beat 3 for wrap
      do_hit(6'd5, 2'd2);
      run_fill({21'h1abcd, 6'd5, 2'd3, 3'd0}, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0);
   endtask

   task automatic t_prefetch;
      // R6: prefetch in a fresh set, victim way 0
      run_fill({21'h00042, 6'd7, 2'd1, 3'd0}, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0);
   endtask

   task automatic t_hit_and_commit;
      // R9: hit on way 2 in the commit cycle of way 0, commit applied last
      run_fill({21'h00100, 6'd9, 2'd0, 3'd0}, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2);
      run_fill({21'h00200, 6'd9, 2'd1, 3'd0}, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0);
      run_fill({21'h00300, 6'd9, 2'd2, 3'd0}, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0);
      run_fill({21'h00400, 6'd9, 2'd3, 3'd0}, 1'b0, 2'd2, 1'b0, 1'b0, 2'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_demand_wrap();
      t_lru_chain();
      t_prefetch();
      t_hit_and_commit();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule